// File: doc/BRIEF.md
# Timestamp-Age Cell Resequencer

This block puts cells back in order at one output of a multipath switch fabric. Each cell that enters carries the timeslot at which it entered the fabric and a small payload tag. The block keeps these cells in a small pool. On every timeslot a compare tree finds the buffered cell that has waited longest, measured against a free-running timeslot counter.

That cell is shown at the output only once its age is strictly greater than a configured bound. The bound is the worst-case transit delay of the fabric. When a cell is that old, every cell that entered before it has already arrived. Releasing cells oldest first therefore keeps them in order.

The output uses a valid/ready handshake and sends at most one cell per timeslot. The input applies backpressure through a ready signal when every pool slot is taken. Ages are taken modulo 2^16, so the counter may wrap. This holds as long as the bound stays below 2^15.

Top module: `cell_reseq`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `out_valid` is 0 and `in_ready` is 1. Any cell buffered before the reset is discarded.
- R2: The cell presented at the output is the buffered cell with the largest age. Age is `(now - stamp) mod 2^16`.
- R3: Buffered cells of equal age leave in slot order, lowest slot first. An accepted cell always takes the lowest-numbered free slot, so cells accepted one by one into an empty pool leave in arrival order.
- R4: `out_valid` is 1 only when the oldest cell's age is strictly greater than `delay_bound`. An age equal to the bound does not release the cell.
- R5: Age arithmetic wraps modulo 2^16. A cell stamped 0xFFF0 has age 21 when `now` is 0x0005.
- R6: A cell leaves the pool only in a cycle with `out_valid` and `out_ready` both high, and at most one cell leaves per cycle. With `out_ready` low, the presented cell stays buffered.
- R7: With all 8 slots occupied and no cell leaving, `in_ready` is 0. A cell offered in that cycle is not accepted and never appears at the output.
- R8: When the pool is full and a cell leaves in the same cycle, `in_ready` is 1. The offered cell is accepted into the freed slot.
- R9: With the pool empty, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timeslot clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An incoming cell is offered |
| in_ready | output | 1 | A free slot exists, or one is freed this cycle |
| in_stamp | input | 16 | Fabric entry timeslot of the offered cell |
| in_tag | input | 8 | Payload tag of the offered cell |
| now | input | 16 | Free-running timeslot counter |
| delay_bound | input | 16 | Worst-case fabric delay in timeslots, below 2^15 |
| out_valid | output | 1 | Oldest cell is older than the bound |
| out_ready | input | 1 | Downstream accepts the presented cell |
| out_stamp | output | 16 | Entry timeslot of the presented cell |
| out_tag | output | 8 | Payload tag of the presented cell |

## Verification
The hardest case to reach is a full pool with an eligible cell leaving in the same cycle as a new cell arrives. This is the only case in which a freed slot is refilled at once. To get there, the bench fills all eight slots with cells that are still too young to leave, holding `out_ready` low. It then offers a cell while the pool is full, to show that the cell is refused. Next it raises `now` so that every buffered cell becomes eligible, and offers a new cell with `out_ready` high. Finally it drains the pool to confirm that the refused cell never appears and that the accepted cell leaves last, once it has aged past the bound.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

    localparam int TS_W  = 16;
    localparam int TAG_W = 8;

    typedef logic [TS_W-1:0]  stamp_t;
    typedef logic [TAG_W-1:0] tag_t;

    typedef struct packed {
        logic   live;
        stamp_t stamp;
        tag_t   tag;
    } cell_t;

    // Age in timeslots, modulo 2^TS_W so counter wrap is harmless.
    function automatic stamp_t age_of(input stamp_t now_t, input stamp_t entry_t);
        return stamp_t'(now_t - entry_t);
    endfunction

endpackage

// File: rtl/rseq_pool.sv
module rseq_pool
    import rseq_pkg::*;
#(
    parameter  int SLOTS = 8,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  stamp_t           wr_stamp,
    input  tag_t             wr_tag,
    input  logic             rel_en,
    input  logic [IDX_W-1:0] rel_idx,
    output logic             space_ok,
    output logic [SLOTS-1:0] live_o,
    output stamp_t           stamp_o [SLOTS],
    output tag_t             tag_o   [SLOTS]
);

    cell_t            slot_q [SLOTS];
    logic [SLOTS-1:0] free_vec;
    logic [IDX_W-1:0] wr_idx;

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            live_o[i]  = slot_q[i].live;
            stamp_o[i] = slot_q[i].stamp;
            tag_o[i]   = slot_q[i].tag;
        end
        free_vec = ~live_o;
        if (rel_en) free_vec[rel_idx] = 1'b1;
        wr_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (free_vec[i]) wr_idx = IDX_W'(i);
        end
        space_ok = |free_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
        end else begin
            if (rel_en) slot_q[rel_idx].live <= 1'b0;
            if (wr_en)  slot_q[wr_idx] <= '{live: 1'b1, stamp: wr_stamp, tag: wr_tag};
        end
    end

    AST_DRAIN_ONE_PER_SLOT: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(live_o) + 1 >= $past($countones(live_o)))); // R6

    AST_STALL_KEEPS_CELLS: assert property (@(posedge clk) disable iff (rst)
        !rel_en |=> ((live_o & $past(live_o)) == $past(live_o))); // R6

    AST_ACCEPT_GROWS_POOL: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rel_en) |=> ($countones(live_o) == $past($countones(live_o)) + 1)); // R7

endmodule

// File: rtl/rseq_oldest_tree.sv
module rseq_oldest_tree
    import rseq_pkg::*;
#(
    parameter  int SLOTS = 8,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  stamp_t           now,
    input  logic [SLOTS-1:0] live,
    input  stamp_t           stamp [SLOTS],
    output logic             win_live,
    output stamp_t           win_age,
    output logic [IDX_W-1:0] win_idx
);

    localparam int LEVELS = $clog2(SLOTS);
    localparam int LEAVES = 1 << LEVELS;

    // Heap layout: node n has children 2n and 2n+1, leaves at LEAVES..2*LEAVES-1.
    logic             nd_live [2*LEAVES];
    stamp_t           nd_age  [2*LEAVES];
    logic [IDX_W-1:0] nd_idx  [2*LEAVES];

    for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
        if (j < SLOTS) begin : g_used
            assign nd_live[LEAVES+j] = live[j];
            assign nd_age[LEAVES+j]  = age_of(now, stamp[j]);
            assign nd_idx[LEAVES+j]  = IDX_W'(j);
        end else begin : g_pad
            assign nd_live[LEAVES+j] = 1'b0;
            assign nd_age[LEAVES+j]  = '0;
            assign nd_idx[LEAVES+j]  = '0;
        end
    end

    for (genvar n = 1; n < LEAVES; n++) begin : g_node
        logic take_right;
        // Right child wins only when strictly older; ties keep the lower index.
        assign take_right = nd_live[2*n+1] &&
                            (!nd_live[2*n] || (nd_age[2*n+1] > nd_age[2*n]));
        assign nd_live[n] = nd_live[2*n] | nd_live[2*n+1];
        assign nd_age[n]  = take_right ? nd_age[2*n+1] : nd_age[2*n];
        assign nd_idx[n]  = take_right ? nd_idx[2*n+1] : nd_idx[2*n];
    end

    assign win_live = nd_live[1];
    assign win_age  = nd_age[1];
    assign win_idx  = nd_idx[1];

    for (genvar k = 0; k < SLOTS; k++) begin : g_chk
        AST_OLDEST_WINS: assert property (@(posedge clk) disable iff (rst)
            live[k] |-> (age_of(now, stamp[k]) <= win_age)); // R2
    end

    AST_WINNER_IS_LIVE: assert property (@(posedge clk) disable iff (rst)
        win_live |-> live[win_idx]); // R2

endmodule

// File: rtl/rseq_age_gate.sv
module rseq_age_gate
    import rseq_pkg::*;
(
    input  logic   win_live,
    input  stamp_t win_age,
    input  stamp_t bound,
    output logic   eligible
);

    // Strictly older than the fabric delay bound: all earlier cells have landed.
    assign eligible = win_live && (win_age > bound);

endmodule

// File: rtl/cell_reseq.sv
module cell_reseq
    import rseq_pkg::*;
#(
    parameter  int SLOTS = 8,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [TS_W-1:0]    in_stamp,
    input  logic [TAG_W-1:0]   in_tag,
    input  logic [TS_W-1:0]    now,
    input  logic [TS_W-1:0]    delay_bound,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [TS_W-1:0]    out_stamp,
    output logic [TAG_W-1:0]   out_tag
);

    logic [SLOTS-1:0] live;
    stamp_t           stamp [SLOTS];
    tag_t             tag   [SLOTS];
    logic             win_live;
    stamp_t           win_age;
    logic [IDX_W-1:0] win_idx;
    logic             eligible;
    logic             fire;
    logic             accept;

    assign fire   = eligible && out_ready;
    assign accept = in_valid && in_ready;

    rseq_pool #(.SLOTS(SLOTS)) u_pool (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (accept),
        .wr_stamp (in_stamp),
        .wr_tag   (in_tag),
        .rel_en   (fire),
        .rel_idx  (win_idx),
        .space_ok (in_ready),
        .live_o   (live),
        .stamp_o  (stamp),
        .tag_o    (tag)
    );

    rseq_oldest_tree #(.SLOTS(SLOTS)) u_tree (
        .clk      (clk),
        .rst      (rst),
        .now      (now),
        .live     (live),
        .stamp    (stamp),
        .win_live (win_live),
        .win_age  (win_age),
        .win_idx  (win_idx)
    );

    rseq_age_gate u_gate (
        .win_live (win_live),
        .win_age  (win_age),
        .bound    (delay_bound),
        .eligible (eligible)
    );

    assign out_valid = eligible;
    assign out_stamp = stamp[win_idx];
    assign out_tag   = tag[win_idx];

    AST_RELEASE_AFTER_BOUND: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (stamp_t'(now - out_stamp) > delay_bound)); // R4

    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (rst)
        (live == '0) |-> !out_valid); // R9

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        ((&live) && !(out_valid && out_ready)) |-> !in_ready); // R7

endmodule

// File: tb/cell_reseq_bench.sv
module cell_reseq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_stamp = '0;
    logic [7:0]  in_tag = '0;
    logic [15:0] now = '0;
    logic [15:0] delay_bound = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_stamp;
    logic [7:0]  out_tag;

    int compared   = 0;
    int mismatched = 0;
    bit done       = 1'b0;

    always #4 clk = ~clk;

    cell_reseq u_cell_reseq (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_stamp(in_stamp), .in_tag(in_tag),
        .now(now), .delay_bound(delay_bound),
        .out_valid(out_valid), .out_ready(out_ready), .out_stamp(out_stamp), .out_tag(out_tag)
    );

    typedef struct packed {
        logic        iv;
        logic [15:0] st;
        logic [7:0]  tg;
        logic [15:0] nw;
        logic [15:0] bd;
        logic        ordy;
        logic        e_ov;
        logic [7:0]  e_tag;
        logic        e_ir;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 16'd95, 8'd1, 16'd100, 16'd10, 1'b0, 1'b0, 8'd0, 1'b1}, // R9 empty
        '{1'b1, 16'd90, 8'd2, 16'd103, 16'd10, 1'b0, 1'b0, 8'd0, 1'b1}, // R4 young
        '{1'b0, 16'd0,  8'd0, 16'd105, 16'd10, 1'b0, 1'b1, 8'd2, 1'b1}, // R2 oldest, held
        '{1'b0, 16'd0,  8'd0, 16'd105, 16'd10, 1'b1, 1'b1, 8'd2, 1'b1}, // R6 released
        '{1'b0, 16'd0,  8'd0, 16'd105, 16'd10, 1'b1, 1'b0, 8'd0, 1'b1}, // R4 age == bound
        '{1'b0, 16'd0,  8'd0, 16'd106, 16'd10, 1'b1, 1'b1, 8'd1, 1'b1}, // R4 age > bound
        '{1'b0, 16'd0,  8'd0, 16'd106, 16'd10, 1'b1, 1'b0, 8'd0, 1'b1}  // R9 drained
    };

    task automatic chk(input string req, input int act, input int exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic iv, input logic [15:0] st, input logic [7:0] tg,
                         input logic [15:0] nw, input logic [15:0] bd, input logic ordy);
        @(negedge clk);
        in_valid    = iv;
        in_stamp    = st;
        in_tag      = tg;
        now         = nw;
        delay_bound = bd;
        out_ready   = ordy;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        out_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        do_reset();
        #1;
        chk("R1 out_valid after reset", int'(out_valid), 0);
        chk("R1 in_ready after reset", int'(in_ready), 1);

        for (int v = 0; v < NVEC; v++) begin
            drive(VECS[v].iv, VECS[v].st, VECS[v].tg, VECS[v].nw, VECS[v].bd, VECS[v].ordy);
            chk("R2/R4/R6 vector out_valid", int'(out_valid), int'(VECS[v].e_ov));
            chk("R7 vector in_ready", int'(in_ready), int'(VECS[v].e_ir));
            if (VECS[v].e_ov) chk("R2 vector out_tag", int'(out_tag), int'(VECS[v].e_tag));
        end

        // R3: equal ages leave in slot (arrival) order
        for (int k = 0; k < 3; k++) drive(1'b1, 16'd190, 8'(10 + k), 16'd200, 16'd5, 1'b0);
        for (int k = 0; k < 3; k++) begin
            drive(1'b0, 16'd0, 8'd0, 16'd200, 16'd5, 1'b1);
            chk("R3 tie order", int'(out_tag), 10 + k);
        end
        drive(1'b0, 16'd0, 8'd0, 16'd200, 16'd5, 1'b0);
        chk("R9 empty after ties", int'(out_valid), 0);

        // R5: counter wrap
        drive(1'b1, 16'hFFF0, 8'd20, 16'hFFF0, 16'd10, 1'b0);
        drive(1'b0, 16'd0, 8'd0, 16'h0005, 16'd10, 1'b0);
        chk("R5 wrapped age eligible", int'(out_valid), 1);
        chk("R5 wrapped stamp", int'(out_stamp), 16'hFFF0);
        drive(1'b0, 16'd0, 8'd0, 16'h0005, 16'd10, 1'b1);
        chk("R5 wrapped tag", int'(out_tag), 20);
        drive(1'b0, 16'd0, 8'd0, 16'h0006, 16'd10, 1'b1);
        chk("R9 empty after wrap", int'(out_valid), 0);

        // R7 / R8: full pool
        for (int k = 0; k < 8; k++) drive(1'b1, 16'd300, 8'(30 + k), 16'd300, 16'd1000, 1'b0);
        drive(1'b1, 16'd0, 8'd99, 16'd300, 16'd1000, 1'b0);
        chk("R7 in_ready low when full", int'(in_ready), 0);
        chk("R4 young cells held", int'(out_valid), 0);
        drive(1'b0, 16'd0, 8'd0, 16'd400, 16'd50, 1'b0);
        chk("R7 refused cell absent", int'(out_tag), 30);
        drive(1'b1, 16'd399, 8'd40, 16'd400, 16'd50, 1'b1);
        chk("R8 in_ready with same-slot release", int'(in_ready), 1);
        chk("R8 released tag", int'(out_tag), 30);
        for (int k = 1; k < 8; k++) begin
            drive(1'b0, 16'd0, 8'd0, 16'd400, 16'd50, 1'b1);
            chk("R6 drain one per slot", int'(out_tag), 30 + k);
        end
        drive(1'b0, 16'd0, 8'd0, 16'd400, 16'd50, 1'b1);
        chk("R4 refill cell still young", int'(out_valid), 0);
        drive(1'b0, 16'd0, 8'd0, 16'd460, 16'd50, 1'b1);
        chk("R8 refill cell accepted", int'(out_tag), 40);
        drive(1'b0, 16'd0, 8'd0, 16'd460, 16'd50, 1'b1);
        chk("R9 empty after drain", int'(out_valid), 0);

        // R1: reset discards buffered cells
        drive(1'b1, 16'd0, 8'd77, 16'd500, 16'd10, 1'b0);
        do_reset();
        in_valid = 1'b0;
        #1;
        chk("R1 reset clears pool", int'(out_valid), 0);
        chk("R1 in_ready after mid reset", int'(in_ready), 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule